// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This combinational control block sits beside the datapath of an in-order five-stage integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it receives the register tags of the instructions in the decode, execute, memory and writeback stages. From these it decides whether the front of the pipeline must freeze, whether a bubble goes into execute, whether the just-fetched instruction must be discarded, and where each execute-stage operand should come from.

Two kinds of stall exist. The first is a load followed at once by a consumer of its result. The second is a control instruction resolved in decode that reads a register still being produced in execute or memory. The decode stage gets no forwarding. A decode-stage branch or indirect jump therefore waits until its producer reaches writeback, where the register file's write-before-read behaviour supplies the value. When a taken branch or jump is in decode and nothing stalls, the instruction fetched behind it is flushed. Operand forwarding reaches execute only, from the memory and writeback stages.

Top module: `hazard_ctrl`

## Requirements
- R1: When the instruction in execute is a register-writing load with a non-zero destination, and that destination equals either decode source, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 in that cycle.
- R2: When the memory-stage instruction writes a non-zero register that is not a load result and matches an execute source, that operand's select is 2'b10.
- R3: When only the writeback-stage instruction writes a non-zero register matching an execute source, that operand's select is 2'b01. This applies to load results as well.
- R4: When the memory and writeback stages both match the same execute source, the memory stage wins (select 2'b10).
- R5: Register 0 never causes forwarding or a stall, even with write enable set. With no forwarding the select is 2'b00, the register file value.
- R6: When `id_ctrl` is 1 and a decode source matches a non-zero destination written by the execute or memory stage, all three stall outputs are 1. A match only in writeback causes no stall.
- R7: `ifid_flush` is 1 exactly when `id_taken` is 1 and no stall condition is active. During any stall it stays 0.
- R8: A producer with write enable 0, or a non-load execute producer feeding a non-control decode instruction, causes no stall and no forwarding.
- R9: A load in the memory stage is never a forwarding source. Its match falls through to the writeback stage or to the register file.
- R10: The two execute operands are selected independently: `fwd_a` follows `ex_rs1` and `fwd_b` follows `ex_rs2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| id_ctrl | input | 1 | Decode holds a branch or indirect jump resolved in decode |
| id_taken | input | 1 | Decode control instruction is taken (branch or jump) |
| ex_rs1 | input | 5 | First source register of the execute instruction |
| ex_rs2 | input | 5 | Second source register of the execute instruction |
| ex_rd | input | 5 | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination register of the writeback instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| ifid_flush | output | 1 | Replace the fetched instruction with a nop |
| fwd_a | output | 2 | Operand A source: 00 register file, 01 writeback, 10 memory |
| fwd_b | output | 2 | Operand B source: 00 register file, 01 writeback, 10 memory |

## Verification
The hardest case to reach is a cycle where several conditions meet. Examples are a taken branch that is also stalled, by a load-use hazard or by its own execute or memory producer, and an execute source that matches both later stages while the memory stage holds a load. The stimulus builds these from an idle tag set and changes one or two fields at a time. Each such vector is followed by its neighbour with a single field moved, such as the producer stepped from memory to writeback or the destination changed to register 0. Every vector pushes its own expected outputs into the scoreboard queue.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    localparam int REG_AW   = 5;
    localparam int NUM_OPND = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;

    // A producer stage: destination and whether it really writes it
    typedef struct packed {
        reg_idx_t rd;
        logic     wen;
    } prod_t;

    // True when the producer updates register r (register 0 never counts)
    function automatic logic prod_hits(prod_t p, reg_idx_t r);
        return p.wen && (p.rd != '0) && (p.rd == r);
    endfunction

endpackage

// File: rtl/opnd_fwd_sel.sv
module opnd_fwd_sel
    import hzc_pkg::*;
#(
    parameter int NSRC = NUM_OPND
) (
    input  reg_idx_t  ex_src [NSRC],
    input  prod_t     mem_p,
    input  logic      mem_is_load,
    input  prod_t     wb_p,
    output opnd_src_e sel    [NSRC]
);

    for (genvar g = 0; g < NSRC; g++) begin : g_opnd
        always_comb begin
            // Memory stage first: it holds the younger value
            if (!mem_is_load && prod_hits(mem_p, ex_src[g]))
                sel[g] = SRC_MEM;
            else if (prod_hits(wb_p, ex_src[g]))
                sel[g] = SRC_WB;
            else
                sel[g] = SRC_REGFILE;
        end

        always_comb begin
            AST_SEL_LEGAL: assert (sel[g] != opnd_src_e'(2'b11))
                else $error("illegal operand select"); // R2
            AST_X0_NO_FWD: assert ((ex_src[g] != '0) || (sel[g] == SRC_REGFILE))
                else $error("register 0 forwarded"); // R5
        end
    end

endmodule

// File: rtl/load_use_det.sv
module load_use_det
    import hzc_pkg::*;
(
    input  reg_idx_t id_rs1,
    input  reg_idx_t id_rs2,
    input  prod_t    ex_p,
    input  logic     ex_is_load,
    output logic     hit
);

    always_comb begin
        hit = ex_is_load && (prod_hits(ex_p, id_rs1) || prod_hits(ex_p, id_rs2));
    end

endmodule

// File: rtl/ctrl_dep_det.sv
module ctrl_dep_det
    import hzc_pkg::*;
(
    input  logic     id_ctrl,
    input  reg_idx_t id_rs1,
    input  reg_idx_t id_rs2,
    input  prod_t    ex_p,
    input  prod_t    mem_p,
    output logic     hit
);

    logic ex_dep;
    logic mem_dep;

    always_comb begin
        ex_dep  = prod_hits(ex_p, id_rs1)  || prod_hits(ex_p, id_rs2);
        mem_dep = prod_hits(mem_p, id_rs1) || prod_hits(mem_p, id_rs2);
        hit     = id_ctrl && (ex_dep || mem_dep);
    end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hzc_pkg::*;
(
    input  logic [4:0] id_rs1,
    input  logic [4:0] id_rs2,
    input  logic       id_ctrl,
    input  logic       id_taken,
    input  logic [4:0] ex_rs1,
    input  logic [4:0] ex_rs2,
    input  logic [4:0] ex_rd,
    input  logic       ex_wen,
    input  logic       ex_load,
    input  logic [4:0] mem_rd,
    input  logic       mem_wen,
    input  logic       mem_load,
    input  logic [4:0] wb_rd,
    input  logic       wb_wen,
    output logic       pc_hold,
    output logic       ifid_hold,
    output logic       idex_bubble,
    output logic       ifid_flush,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b
);

    prod_t     ex_p, mem_p, wb_p;
    reg_idx_t  ex_src [NUM_OPND];
    opnd_src_e sel    [NUM_OPND];
    logic      lu_hit;
    logic      cd_hit;
    logic      stall;

    always_comb begin
        ex_p      = '{rd: ex_rd,  wen: ex_wen};
        mem_p     = '{rd: mem_rd, wen: mem_wen};
        wb_p      = '{rd: wb_rd,  wen: wb_wen};
        ex_src[0] = ex_rs1;
        ex_src[1] = ex_rs2;
    end

    load_use_det u_lu (
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_p       (ex_p),
        .ex_is_load (ex_load),
        .hit        (lu_hit)
    );

    ctrl_dep_det u_cd (
        .id_ctrl (id_ctrl),
        .id_rs1  (id_rs1),
        .id_rs2  (id_rs2),
        .ex_p    (ex_p),
        .mem_p   (mem_p),
        .hit     (cd_hit)
    );

    opnd_fwd_sel #(.NSRC(NUM_OPND)) u_fwd (
        .ex_src      (ex_src),
        .mem_p       (mem_p),
        .mem_is_load (mem_load),
        .wb_p        (wb_p),
        .sel         (sel)
    );

    always_comb begin
        stall       = lu_hit || cd_hit;
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
        // A branch is only resolved once nothing holds it back
        ifid_flush  = id_taken && !stall;
        fwd_a       = sel[0];
        fwd_b       = sel[1];
    end

    always_comb begin
        AST_FLUSH_EXCL_HOLD: assert (!(ifid_flush && pc_hold))
            else $error("flush during stall"); // R7
        AST_TAKEN_ACTS: assert (!id_taken || ifid_flush || pc_hold)
            else $error("taken branch neither flushed nor held"); // R7
        AST_MEM_LOAD_NOFWD: assert (!mem_load || (fwd_a != 2'b10 && fwd_b != 2'b10))
            else $error("memory-stage load forwarded"); // R9
        AST_LU_STALL_SEEN: assert (!lu_hit || (pc_hold && idex_bubble))
            else $error("load-use not stalled"); // R1
    end

endmodule

// File: tb/hazard_ctrl_test.sv
`timescale 1ns/1ps
module hazard_ctrl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    typedef struct {
        logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
        logic id_ctrl, id_taken, ex_wen, ex_load, mem_wen, mem_load, wb_wen;
    } stim_t;

    typedef struct {
        logic       stall;
        logic       flush;
        logic [1:0] fa;
        logic [1:0] fb;
        string      req;
    } exp_t;

    stim_t s;
    exp_t  q [$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    logic pc_hold, ifid_hold, idex_bubble, ifid_flush;
    logic [1:0] fwd_a, fwd_b;

    hazard_ctrl uut (
        .id_rs1(s.id_rs1), .id_rs2(s.id_rs2), .id_ctrl(s.id_ctrl), .id_taken(s.id_taken),
        .ex_rs1(s.ex_rs1), .ex_rs2(s.ex_rs2), .ex_rd(s.ex_rd), .ex_wen(s.ex_wen),
        .ex_load(s.ex_load), .mem_rd(s.mem_rd), .mem_wen(s.mem_wen), .mem_load(s.mem_load),
        .wb_rd(s.wb_rd), .wb_wen(s.wb_wen),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    function automatic stim_t idle();
        stim_t t;
        t.id_rs1 = 0; t.id_rs2 = 0; t.ex_rs1 = 0; t.ex_rs2 = 0;
        t.ex_rd = 0; t.mem_rd = 0; t.wb_rd = 0;
        t.id_ctrl = 0; t.id_taken = 0; t.ex_wen = 0; t.ex_load = 0;
        t.mem_wen = 0; t.mem_load = 0; t.wb_wen = 0;
        return t;
    endfunction

    task automatic drive(input stim_t t, input logic st, input logic fl,
                         input logic [1:0] fa, input logic [1:0] fb, input string req);
        exp_t e;
        @(posedge clk);
        s = t;
        e.stall = st; e.flush = fl; e.fa = fa; e.fb = fb; e.req = req;
        q.push_back(e);
    endtask

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.req, "pc_hold",     pc_hold,     e.stall);
            cmp(e.req, "ifid_hold",   ifid_hold,   e.stall);
            cmp(e.req, "idex_bubble", idex_bubble, e.stall);
            cmp(e.req, "ifid_flush",  ifid_flush,  e.flush);
            cmp(e.req, "fwd_a",       fwd_a,       e.fa);
            cmp(e.req, "fwd_b",       fwd_b,       e.fb);
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        stim_t t;
        s = idle();
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset / idle state, no producers: R8
        drive(idle(), 0, 0, 2'b00, 2'b00, "R8 idle");

        // R1: load in EX feeding decode rs2
        t = idle(); t.ex_load = 1; t.ex_wen = 1; t.ex_rd = 5; t.id_rs2 = 5;
        drive(t, 1, 0, 2'b00, 2'b00, "R1 load-use");

        // R5: load targets x0 and decode reads x0
        t = idle(); t.ex_load = 1; t.ex_wen = 1; t.ex_rd = 0;
        drive(t, 0, 0, 2'b00, 2'b00, "R5 load x0");

        // R8: non-load EX producer, non-control consumer
        t = idle(); t.ex_wen = 1; t.ex_rd = 5; t.id_rs1 = 5;
        drive(t, 0, 0, 2'b00, 2'b00, "R8 alu no stall");

        // R2: MEM forwarding to A
        t = idle(); t.mem_wen = 1; t.mem_rd = 7; t.ex_rs1 = 7;
        drive(t, 0, 0, 2'b10, 2'b00, "R2 mem fwd");

        // R3 / R10: WB forwarding to B only
        t = idle(); t.wb_wen = 1; t.wb_rd = 9; t.ex_rs2 = 9; t.ex_rs1 = 8;
        drive(t, 0, 0, 2'b00, 2'b01, "R3 wb fwd");

        // R4: both match, MEM wins
        t = idle(); t.mem_wen = 1; t.mem_rd = 4; t.wb_wen = 1; t.wb_rd = 4; t.ex_rs1 = 4;
        drive(t, 0, 0, 2'b10, 2'b00, "R4 priority");

        // R8: MEM not writing, WB supplies
        t = idle(); t.mem_rd = 4; t.wb_wen = 1; t.wb_rd = 4; t.ex_rs1 = 4;
        drive(t, 0, 0, 2'b01, 2'b00, "R8 mem wen off");

        // R5: x0 with write enable everywhere
        t = idle(); t.mem_wen = 1; t.wb_wen = 1; t.ex_wen = 1; t.id_ctrl = 1;
        drive(t, 0, 0, 2'b00, 2'b00, "R5 x0 no fwd");

        // R9: MEM load skipped, WB takes over
        t = idle(); t.mem_wen = 1; t.mem_load = 1; t.mem_rd = 6; t.wb_wen = 1; t.wb_rd = 6;
        t.ex_rs1 = 6; t.ex_rs2 = 6;
        drive(t, 0, 0, 2'b01, 2'b01, "R9 mem load to wb");

        // R9: MEM load alone falls to register file
        t = idle(); t.mem_wen = 1; t.mem_load = 1; t.mem_rd = 6; t.ex_rs1 = 6;
        drive(t, 0, 0, 2'b00, 2'b00, "R9 mem load to rf");

        // R6 / R7: taken branch on EX producer stalls, no flush
        t = idle(); t.id_ctrl = 1; t.id_taken = 1; t.id_rs1 = 3; t.ex_wen = 1; t.ex_rd = 3;
        drive(t, 1, 0, 2'b00, 2'b00, "R6 branch ex dep");

        // R6: branch on MEM producer
        t = idle(); t.id_ctrl = 1; t.id_taken = 1; t.id_rs2 = 3; t.mem_wen = 1; t.mem_rd = 3;
        drive(t, 1, 0, 2'b00, 2'b00, "R6 branch mem dep");

        // R6 / R7: producer now in WB, branch resolves and flushes
        t = idle(); t.id_ctrl = 1; t.id_taken = 1; t.id_rs1 = 3; t.wb_wen = 1; t.wb_rd = 3;
        drive(t, 0, 1, 2'b00, 2'b00, "R7 branch wb resolves");

        // R7: plain taken jump
        t = idle(); t.id_taken = 1;
        drive(t, 0, 1, 2'b00, 2'b00, "R7 jump flush");

        // R7: taken jump blocked by load-use
        t = idle(); t.id_taken = 1; t.ex_load = 1; t.ex_wen = 1; t.ex_rd = 12; t.id_rs1 = 12;
        drive(t, 1, 0, 2'b00, 2'b00, "R7 flush held in stall");

        // R10: independent operands
        t = idle(); t.mem_wen = 1; t.mem_rd = 10; t.wb_wen = 1; t.wb_rd = 11;
        t.ex_rs1 = 10; t.ex_rs2 = 11;
        drive(t, 0, 0, 2'b10, 2'b01, "R10 split operands");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule